// File: doc/BRIEF.md
# Byte-Enable Gathering Write Buffer

This block sits between a processor and a memory that is addressed in 32-bit longs. The processor issues a stream of narrow commands: a start command that sets a 17-bit long address, then byte, word and long writes and skips. The buffer places each value in its lane, builds a four-bit lane-enable mask beside the data, and queues each long once it is complete. The memory then updates only the enabled lanes, so a partial write never needs a read-modify-write.

Completed longs sit in an eight-entry queue. They leave through a registered write port, one per clock while the slot grant is high, at addresses that step by one long. When the queue is full the command port drops its ready signal. A word that would straddle an odd lane, or a long that would start at a nonzero lane, first closes the current long, with its unused lanes disabled. The word or long then goes to lane 0 of the next long.

Top module: `bg_writebuf`

## Requirements
- R1: After reset `mem_we` is 0, `cmd_ready` is 1, the lane pointer is at lane 0 and the current long address is 0.
- R2: An output entry is `mem_addr` (17-bit long address), `mem_data` (32 bits) and `mem_be`. Bit i of `mem_be` enables data bits 8i+7..8i. Disabled lanes carry zero data.
- R3: `cmd_op` codes are 0 idle, 1 start, 2 write byte, 3 write word, 4 write long, 5 skip byte, 6 skip word, 7 skip long. Lanes fill upward from lane 0. A byte written at lane p takes `cmd_data[7:0]` into bits 8p+7..8p. A word at lane p takes `cmd_data[15:0]` into lanes p and p+1.
- R4: Skip byte, write byte, write word yields one entry with enables 4'b1110. A long write yields 4'b1111. Skip word then write word yields 4'b1100.
- R5: A long skip emits an entry with enables 4'b0000, and the address still advances past it.
- R6: A start while a long is partly filled first emits that long at its own address, for example enables 4'b0001 after a single byte write. The next long then begins at `cmd_addr`. A start at lane 0 emits nothing.
- R7: Each emitted entry advances the long address by one, modulo 2^17.
- R8: A word command at an odd lane, or a long command at a nonzero lane, holds `cmd_ready` low for one cycle while the partial long is emitted. The command is then accepted and placed at lane 0 of the next long.
- R9: An accepted command that completes a long appears on the `mem_*` outputs two clock edges later when `mem_gnt` is high. Entries leave in order, at one per clock.
- R10: The queue holds 8 entries. `cmd_ready` is low while it is full, and no entry is lost or duplicated.
- R11: While `mem_gnt` is low, `mem_we` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code (R3) |
| cmd_data | input | 32 | Write value, right-aligned |
| cmd_addr | input | 17 | Long address for a start command |
| cmd_ready | output | 1 | Command accepted this cycle when valid |
| mem_gnt | input | 1 | Memory slot granted for a drain |
| mem_we | output | 1 | Entry present on the write port |
| mem_addr | output | 17 | Long address of the entry |
| mem_data | output | 32 | Lane-placed data |
| mem_be | output | 4 | Per-lane write enables |

## Verification
The assertions check on every cycle that an accepted word never lands on an odd lane and an accepted long only lands at lane 0. They also check that a start leaves an empty long, that nothing is pushed into a full queue, and that writes go out only after a grant. Lane placement, the mask values of the documented command sequences, flushing on start, address wrap, and lossless backpressure cannot be checked by these properties alone. Those behaviours are shown by the bench's scenarios, which compare a behavioural queue model against the ports on every clock.

// File: rtl/bg_pkg.sv
package bg_pkg;
  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_START  = 3'd1,
    OP_PUT_B  = 3'd2,
    OP_PUT_H  = 3'd3,
    OP_PUT_W  = 3'd4,
    OP_SKIP_B = 3'd5,
    OP_SKIP_H = 3'd6,
    OP_SKIP_W = 3'd7
  } bg_op_e;
endpackage

// File: rtl/bg_pack.sv
// Lane placement and mask generation for one fill command (R3).
module bg_pack
  import bg_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  bg_op_e                         op,
  input  logic [$clog2(LANES)-1:0]       ptr,
  input  logic [LANES*LANE_W-1:0]        din,
  output logic [LANES-1:0]               be,
  output logic [LANES*LANE_W-1:0]        dout,
  output logic [$clog2(LANES):0]         span,
  output logic                           is_fill,
  output logic                           misalign
);
  localparam int PW = $clog2(LANES);
  localparam int EW = PW + 2;

  logic                    is_write;
  logic [EW-1:0]           lo, hi;
  logic [LANES*LANE_W-1:0] shifted;
  logic [PW:0]             span_m1;

  always_comb begin
    unique case (op)
      OP_PUT_B, OP_SKIP_B: span = (PW+1)'(1);
      OP_PUT_H, OP_SKIP_H: span = (PW+1)'(2);
      OP_PUT_W, OP_SKIP_W: span = (PW+1)'(LANES);
      default:             span = '0;
    endcase
  end

  assign is_write = (op == OP_PUT_B) || (op == OP_PUT_H) || (op == OP_PUT_W);
  assign is_fill  = (span != '0);
  assign span_m1  = span - 1'b1;
  assign misalign = is_fill && (({1'b0, ptr} & span_m1) != '0);
  assign lo       = {2'b00, ptr};
  assign hi       = lo + {1'b0, span};
  assign shifted  = din << (ptr * LANE_W);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign be[g] = is_write && (lo <= EW'(g)) && (EW'(g) < hi);
    assign dout[g*LANE_W +: LANE_W] = be[g] ? shifted[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/bg_fifo.sv
// Entry queue with registered read port; storage has no reset so it maps to RAM.
module bg_fifo #(
  parameter int W     = 53,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         gnt,
  output logic         full,
  output logic         out_valid,
  output logic [W-1:0] out_data
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  store [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic          pop;

  assign pop  = gnt && (cnt != '0);
  assign full = (cnt == (AW+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (push) store[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp        <= '0;
      rp        <= '0;
      cnt       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop) begin
        rp       <= rp + 1'b1;
        out_data <= store[rp];
      end
      out_valid <= pop;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  a_r10_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= (AW+1)'(DEPTH));
endmodule

// File: rtl/bg_writebuf.sv
module bg_writebuf
  import bg_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DEPTH  = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cmd_valid,
  input  logic [2:0]               cmd_op,
  input  logic [LANES*LANE_W-1:0]  cmd_data,
  input  logic [ADDR_W-1:0]        cmd_addr,
  output logic                     cmd_ready,
  input  logic                     mem_gnt,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [LANES*LANE_W-1:0]  mem_data,
  output logic [LANES-1:0]         mem_be
);
  localparam int DW    = LANES * LANE_W;
  localparam int PW    = $clog2(LANES);
  localparam int ENT_W = ADDR_W + DW + LANES;

  bg_op_e            op;
  logic [PW-1:0]     ptr;
  logic [DW-1:0]     acc_data, lane_data, merged_data, push_data;
  logic [LANES-1:0]  acc_be, lane_be, merged_be, push_be;
  logic [ADDR_W-1:0] acc_addr;
  logic [PW:0]       span, fill_end;
  logic              is_fill, misalign, wrap;
  logic              fifo_full, take, realign_go, start_go, fill_go, push;
  logic [ENT_W-1:0]  out_ent;

  assign op = bg_op_e'(cmd_op);

  bg_pack #(.LANES(LANES), .LANE_W(LANE_W)) u_pack (
    .op(op), .ptr(ptr), .din(cmd_data), .be(lane_be), .dout(lane_data),
    .span(span), .is_fill(is_fill), .misalign(misalign)
  );

  assign fill_end    = {1'b0, ptr} + span;
  assign wrap        = (fill_end == (PW+1)'(LANES));
  assign merged_data = acc_data | lane_data;
  assign merged_be   = acc_be | lane_be;

  // A misaligned fill spends one cycle closing the current long.
  assign cmd_ready  = !fifo_full && !(is_fill && misalign);
  assign take       = cmd_valid && cmd_ready;
  assign realign_go = cmd_valid && is_fill && misalign && !fifo_full;
  assign start_go   = take && (op == OP_START);
  assign fill_go    = take && is_fill;

  assign push      = realign_go || (start_go && ptr != '0) || (fill_go && wrap);
  assign push_data = fill_go ? merged_data : acc_data;
  assign push_be   = fill_go ? merged_be : acc_be;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      acc_data <= '0;
      acc_be   <= '0;
      acc_addr <= '0;
    end else if (realign_go) begin
      ptr      <= '0;
      acc_data <= '0;
      acc_be   <= '0;
      acc_addr <= acc_addr + 1'b1;
    end else if (start_go) begin
      ptr      <= '0;
      acc_data <= '0;
      acc_be   <= '0;
      acc_addr <= cmd_addr;
    end else if (fill_go) begin
      if (wrap) begin
        ptr      <= '0;
        acc_data <= '0;
        acc_be   <= '0;
        acc_addr <= acc_addr + 1'b1;
      end else begin
        ptr      <= fill_end[PW-1:0];
        acc_data <= merged_data;
        acc_be   <= merged_be;
      end
    end
  end

  bg_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din({acc_addr, push_data, push_be}),
    .gnt(mem_gnt), .full(fifo_full), .out_valid(mem_we), .out_data(out_ent)
  );

  assign mem_addr = out_ent[ENT_W-1 -: ADDR_W];
  assign mem_data = out_ent[LANES +: DW];
  assign mem_be   = out_ent[LANES-1:0];

  a_r8_word_aligned: assert property (@(posedge clk) disable iff (rst)
    (fill_go && span == (PW+1)'(2)) |-> !ptr[0]);
  a_r8_long_aligned: assert property (@(posedge clk) disable iff (rst)
    (fill_go && span == (PW+1)'(LANES)) |-> (ptr == '0));
  a_r6_start_clears_lane: assert property (@(posedge clk) disable iff (rst)
    start_go |=> (ptr == '0 && acc_be == '0));
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> !fifo_full);
  a_r11_we_only_granted: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(mem_gnt));
endmodule

// File: tb/sim_bg_writebuf.sv
`timescale 1ns/1ps
module sim_bg_writebuf;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [31:0] cmd_data = '0;
  logic [16:0] cmd_addr = '0;
  logic        cmd_ready;
  logic        mem_gnt = 1'b1;
  logic        mem_we;
  logic [16:0] mem_addr;
  logic [31:0] mem_data;
  logic [3:0]  mem_be;

  int checks = 0;
  int errors = 0;
  bit run = 0;

  always #10 clk = ~clk;

  bg_writebuf u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_addr(cmd_addr), .cmd_ready(cmd_ready),
    .mem_gnt(mem_gnt), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_be(mem_be)
  );

  // ---------------- behavioural reference ----------------
  logic [52:0] mq[$];
  logic [52:0] outlog[$];
  int          m_ptr;
  logic [31:0] m_d;
  logic [3:0]  m_be;
  logic [16:0] m_addr;
  bit          exp_we;
  logic [52:0] exp_ent;
  bit          m_room;
  int          m_s;

  function automatic int span_of(logic [2:0] op);
    case (op)
      3'd2, 3'd5: return 1;
      3'd3, 3'd6: return 2;
      3'd4, 3'd7: return 4;
      default:    return 0;
    endcase
  endfunction

  function automatic bit off_grid(logic [2:0] op, int p);
    int s = span_of(op);
    return (s != 0) && ((p % s) != 0);
  endfunction

  task automatic m_emit();
    mq.push_back({m_addr, m_d, m_be});
    m_addr = m_addr + 17'd1;
    m_d = '0; m_be = '0; m_ptr = 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); m_ptr = 0; m_d = '0; m_be = '0; m_addr = '0;
      exp_we = 0; exp_ent = '0;
    end else begin
      m_room = (mq.size() < 8);
      m_s = span_of(cmd_op);
      if (mq.size() > 0 && mem_gnt) begin
        exp_ent = mq.pop_front();
        exp_we = 1;
      end else begin
        exp_we = 0;
      end
      if (cmd_valid && m_room) begin
        if (off_grid(cmd_op, m_ptr)) begin
          m_emit();
        end else if (cmd_op == 3'd1) begin
          if (m_ptr != 0) m_emit();
          m_addr = cmd_addr; m_d = '0; m_be = '0; m_ptr = 0;
        end else if (m_s != 0) begin
          for (int k = 0; k < m_s; k++) begin
            m_be[m_ptr+k] = (cmd_op < 3'd5);
            if (cmd_op < 3'd5) m_d[8*(m_ptr+k) +: 8] = cmd_data[8*k +: 8];
          end
          m_ptr = m_ptr + m_s;
          if (m_ptr == 4) begin
            m_addr = m_addr - 17'd0;
            mq.push_back({m_addr, m_d, m_be});
            m_addr = m_addr + 17'd1;
            m_d = '0; m_be = '0; m_ptr = 0;
          end
        end
      end
    end
  end

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model (R9, R10, R8 ready behaviour).
  always @(negedge clk) begin
    if (!rst && run) begin
      check(mem_we == exp_we && (!exp_we || {mem_addr, mem_data, mem_be} == exp_ent),
            "R9 write port vs model", {10'd0, mem_we, mem_addr, mem_data, mem_be},
            {10'd0, exp_we, exp_ent});
      check(cmd_ready == ((mq.size() < 8) && !off_grid(cmd_op, m_ptr)),
            "R10 R8 cmd_ready vs model", 64'(cmd_ready),
            64'((mq.size() < 8) && !off_grid(cmd_op, m_ptr)));
      if (mem_we) outlog.push_back({mem_addr, mem_data, mem_be});
    end
  end

  task automatic send(input logic [2:0] op, input logic [31:0] d, input logic [16:0] a);
    bit r;
    @(posedge clk); #2;
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_addr = a;
    forever begin
      @(negedge clk); r = cmd_ready;
      @(posedge clk);
      if (r) break;
    end
    #2; cmd_valid = 1'b0; cmd_op = 3'd0;
  endtask

  task automatic expect_ent(int idx, logic [52:0] e, string tag);
    if (idx >= outlog.size()) check(0, tag, 64'(outlog.size()), 64'(idx + 1));
    else check(outlog[idx] == e, tag, 64'(outlog[idx]), 64'(e));
  endtask

  task automatic finish_report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_report();
  end

  initial begin
    bit r;
    repeat (3) @(posedge clk);
    #2; rst = 1'b0; run = 1;
    @(negedge clk);
    check(mem_we == 1'b0 && cmd_ready == 1'b1, "R1 reset state",
          {mem_we, cmd_ready}, 64'b01);

    send(3'd1, 0, 17'h100);            // start
    send(3'd5, 0, 0);                  // skip byte
    send(3'd2, 32'hAA, 0);             // byte
    send(3'd3, 32'hBBCC, 0);           // word -> 1110
    send(3'd4, 32'h1234_5678, 0);      // long -> 1111
    send(3'd6, 0, 0);                  // skip word
    send(3'd3, 32'h5555, 0);           // word -> 1100
    send(3'd7, 0, 0);                  // skip long -> 0000
    send(3'd2, 32'h77, 0);             // pending 0001
    send(3'd1, 0, 17'h1FFFF);          // flush, new base
    send(3'd2, 32'h11, 0);
    send(3'd3, 32'h2222, 0);           // word at lane 1 -> realign
    send(3'd4, 32'h99, 0);             // long at lane 2 -> realign
    repeat (6) @(posedge clk);

    // Backpressure with no grant (R10, R11).
    #2; mem_gnt = 1'b0;
    send(3'd1, 0, 17'h40);
    for (int i = 0; i < 8; i++) send(3'd4, 32'hA0 + i, 0);
    @(posedge clk); #2;
    cmd_valid = 1'b1; cmd_op = 3'd4; cmd_data = 32'hA8;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(cmd_ready == 1'b0, "R10 ready low when queue full", 64'(cmd_ready), 0);
      check(mem_we == 1'b0, "R11 no write without grant", 64'(mem_we), 0);
    end
    @(posedge clk); #2; mem_gnt = 1'b1;
    forever begin
      @(negedge clk); r = cmd_ready;
      @(posedge clk);
      if (r) break;
    end
    #2; cmd_valid = 1'b0; cmd_op = 3'd0;

    send(3'd2, 32'h01, 0);
    send(3'd2, 32'h02, 0);
    send(3'd2, 32'h03, 0);
    send(3'd2, 32'h04, 0);
    repeat (20) @(posedge clk);

    expect_ent(0, {17'h100, 32'hBBCC_AA00, 4'b1110}, "R4 R2 skipB+B+W mask 1110");
    expect_ent(1, {17'h101, 32'h1234_5678, 4'b1111}, "R4 long mask 1111");
    expect_ent(2, {17'h102, 32'h5555_0000, 4'b1100}, "R4 skipW+W mask 1100");
    expect_ent(3, {17'h103, 32'h0, 4'b0000}, "R5 long skip mask 0000");
    expect_ent(4, {17'h104, 32'h77, 4'b0001}, "R6 start flushes pending 0001");
    expect_ent(5, {17'h1FFFF, 32'h11, 4'b0001}, "R8 odd word closes long");
    expect_ent(6, {17'h00000, 32'h2222, 4'b0011}, "R7 R8 wrap and realigned word");
    expect_ent(7, {17'h00001, 32'h99, 4'b1111}, "R8 realigned long");
    for (int i = 0; i < 9; i++)
      expect_ent(8 + i, {17'h40 + 17'(i), 32'hA0 + 32'(i), 4'b1111}, "R10 no entry lost");
    expect_ent(17, {17'h49, 32'h0403_0201, 4'b1111}, "R3 byte lane placement");
    check(outlog.size() == 18, "R6 start at lane 0 emits nothing",
          64'(outlog.size()), 64'd18);
    finish_report();
  end
endmodule